// File: doc/BRIEF.md
# PWM Channel with External Clear

This block is a single timer channel output stage. An up-counter runs from zero to a period value and then wraps. The wrap produces a one-cycle update pulse, and at that pulse the counter loads new period and compare values from its inputs. A mode select turns the counter and compare value into a reference level. The modes are frozen, set on match, clear on match, toggle on match, forced low, forced high, and two edge-aligned PWM shapes. The final pin is the reference with an optional inversion, gated by an output enable.

A trigger input, typically the output of a current-sense comparator, can pull the reference low in mid-period. The trigger passes through a polarity choice, a capture stage and a glitch filter of 1, 2, 4 or 8 samples. When clearing is enabled and the channel is in a compare or PWM mode, a conditioned trigger forces the reference low at once. It also sets a latch that keeps the reference low until the next update pulse, which gives cycle-by-cycle current limiting. The counter always runs on the block clock, so the trigger never acts as a clock source.

Top module: `pwm_clear_channel`

## Requirements
- R1: When `cnt_en_i` is 1 the counter increments each clock. In the cycle where it equals the active period, `update_o` is 1 and the next value is 0. With `cnt_en_i` at 0 the counter holds and `update_o` is 0. After reset the counter and the active period and compare values are 0.
- R2: `period_i` and `compare_i` are sampled only at an update pulse. A change between updates does not alter the running period or compare until the next wrap.
- R3: Mode code 6 gives a reference of 1 while counter < compare and 0 otherwise. Mode code 7 gives the inverse level.
- R4: Mode codes 0 to 3 use a held state. Code 0 freezes it. Codes 1, 2 and 3 set it to 1, clear it to 0, or invert it when the counter equals the compare value, and the new level shows in the following cycle.
- R5: Mode code 4 drives the reference to 0 and code 5 drives it to 1 in the same cycle, regardless of the counter.
- R6: With `clr_en_i` at 1 and a compare or PWM mode (codes 0-3, 6, 7), a conditioned trigger drives the reference to 0. With a filter length of 1, a raw trigger change driven during cycle c lowers the reference in cycle c+2.
- R7: Once cleared, the reference stays 0 until the update pulse that follows, even if the trigger goes inactive earlier.
- R8: If the conditioned trigger is still active at an update pulse, the clear latch sets again, and the reference stays 0 through the new period.
- R9: In mode codes 4 and 5 the trigger is ignored and leaves no latched clear behind.
- R10: With `clr_en_i` at 0 the trigger has no effect on the reference.
- R11: `trig_pol_i` = 0 treats a high trigger as active. `trig_pol_i` = 1 treats a low trigger as active.
- R12: `filt_sel_i` = s sets a filter length N = 2^s. The conditioned trigger changes only after N consecutive captured samples at the new level, so a raw change in cycle c clears the reference in cycle c+N+1, and shorter pulses are ignored.
- R13: `oc_pin_o` equals the reference XOR `out_pol_i` when `out_en_i` is 1, and 0 when `out_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Counter run enable |
| period_i | input | CNT_W | Period (top count), loaded at update |
| compare_i | input | CNT_W | Compare value, loaded at update |
| mode_i | input | 3 | Reference mode code (0 frozen, 1 set, 2 clear, 3 toggle, 4 force low, 5 force high, 6 PWM, 7 inverted PWM) |
| clr_en_i | input | 1 | Enables the external clear |
| trig_i | input | 1 | Raw external clear trigger |
| trig_pol_i | input | 1 | Trigger polarity, 1 = active low |
| filt_sel_i | input | FSEL_W | Filter length select, N = 2^value |
| out_pol_i | input | 1 | Pin inversion |
| out_en_i | input | 1 | Pin enable, idle level 0 |
| oc_ref_o | output | 1 | Reference level |
| oc_pin_o | output | 1 | Final output pin |
| cnt_o | output | CNT_W | Counter value |
| update_o | output | 1 | Update pulse at wrap |

## Verification
The hardest situation to reach is a trigger that is still active when the counter wraps, because the latch then has to be released and set again on the same edge. The bench aligns to a known count, raises the trigger late in one period and keeps it high across the wrap. It then drops the trigger early in the next period and checks that the reference stays low to the end of that period and recovers only after the following wrap. The filter case uses a similar method. The bench uses a pulse one sample too short and a pulse exactly long enough, places both early in a period where the PWM level would otherwise be high, and checks the cycle in which the clear first appears.

// File: rtl/pwm_clear_pkg.sv
package pwm_clear_pkg;

    typedef enum logic [2:0] {
        OCM_FROZEN       = 3'd0,
        OCM_SET_ON_MATCH = 3'd1,
        OCM_CLR_ON_MATCH = 3'd2,
        OCM_TOGGLE       = 3'd3,
        OCM_FORCE_LOW    = 3'd4,
        OCM_FORCE_HIGH   = 3'd5,
        OCM_PWM_A        = 3'd6,
        OCM_PWM_B        = 3'd7
    } ocm_e;

    // Per-cycle compare results from the counter.
    typedef struct packed {
        logic wrap;   // counter at period and running
        logic eq;     // counter equals compare
        logic lt;     // counter below compare
    } cnt_flags_t;

    function automatic logic ocm_is_forced(ocm_e m);
        return (m == OCM_FORCE_LOW) || (m == OCM_FORCE_HIGH);
    endfunction

    function automatic logic ocm_is_pwm(ocm_e m);
        return (m == OCM_PWM_A) || (m == OCM_PWM_B);
    endfunction

    function automatic logic ocm_clearable(ocm_e m);
        return !ocm_is_forced(m);
    endfunction

endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt
    import pwm_clear_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic [CNT_W-1:0] cnt_o,
    output cnt_flags_t       flags_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] arr_q;
    logic [CNT_W-1:0] ccr_q;
    logic             at_top;

    assign at_top = (cnt_q == arr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            arr_q <= '0;
            ccr_q <= '0;
        end else if (en_i) begin
            if (at_top) begin
                cnt_q <= '0;
                arr_q <= period_i;
                ccr_q <= compare_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        flags_o.wrap = en_i && at_top;
        flags_o.eq   = (cnt_q == ccr_q);
        flags_o.lt   = (cnt_q < ccr_q);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_trig_cond.sv
module pwm_trig_cond #(
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             pol_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             level_o
);

    localparam int MAX_LOG = (1 << SEL_W) - 1;
    localparam int RUN_W   = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [SYNC_STAGES-1:0] stage_q;
    logic                   sample;
    logic                   lvl_q;
    logic [RUN_W-1:0]       run_q;
    logic [RUN_W-1:0]       run_lim;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= 1'b0;
                else     stage_q[0] <= trig_i ^ pol_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sample  = stage_q[SYNC_STAGES-1];
    assign run_lim = RUN_W'((32'd1 << sel_i) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (sample == lvl_q) begin
            run_q <= '0;
        end else if (run_q >= run_lim) begin
            lvl_q <= sample;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level_o = lvl_q;

endmodule

// File: rtl/pwm_ref_gen.sv
module pwm_ref_gen
    import pwm_clear_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ocm_e       mode_i,
    input  cnt_flags_t flags_i,
    input  logic       clr_en_i,
    input  logic       trig_lvl_i,
    output logic       ref_o
);

    logic oc_state_q;
    logic oc_state_d;
    logic raw_ref;
    logic clr_hit;
    logic clr_q;
    logic clr_act;

    always_comb begin
        oc_state_d = oc_state_q;
        unique case (mode_i)
            OCM_FROZEN:       oc_state_d = oc_state_q;
            OCM_SET_ON_MATCH: if (flags_i.eq) oc_state_d = 1'b1;
            OCM_CLR_ON_MATCH: if (flags_i.eq) oc_state_d = 1'b0;
            OCM_TOGGLE:       if (flags_i.eq) oc_state_d = !oc_state_q;
            OCM_FORCE_LOW:    oc_state_d = 1'b0;
            OCM_FORCE_HIGH:   oc_state_d = 1'b1;
            OCM_PWM_A:        oc_state_d = flags_i.lt;
            OCM_PWM_B:        oc_state_d = !flags_i.lt;
            default:          oc_state_d = oc_state_q;
        endcase
    end

    always_comb begin
        if (mode_i == OCM_PWM_A)           raw_ref = flags_i.lt;
        else if (mode_i == OCM_PWM_B)      raw_ref = !flags_i.lt;
        else if (mode_i == OCM_FORCE_HIGH) raw_ref = 1'b1;
        else if (mode_i == OCM_FORCE_LOW)  raw_ref = 1'b0;
        else                               raw_ref = oc_state_q;
    end

    assign clr_hit = ocm_clearable(mode_i) && clr_en_i && trig_lvl_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_state_q <= 1'b0;
            clr_q      <= 1'b0;
        end else begin
            oc_state_q <= oc_state_d;
            if (flags_i.wrap) clr_q <= clr_hit;
            else if (clr_hit) clr_q <= 1'b1;
        end
    end

    assign clr_act = ocm_clearable(mode_i) && (clr_q || clr_hit);
    assign ref_o   = raw_ref && !clr_act;

endmodule

// File: rtl/pwm_clear_channel.sv
module pwm_clear_channel
    import pwm_clear_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FSEL_W      = 2,
    parameter int SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  compare_i,
    input  logic [2:0]        mode_i,
    input  logic              clr_en_i,
    input  logic              trig_i,
    input  logic              trig_pol_i,
    input  logic [FSEL_W-1:0] filt_sel_i,
    input  logic              out_pol_i,
    input  logic              out_en_i,
    output logic              oc_ref_o,
    output logic              oc_pin_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              update_o
);

    ocm_e       mode;
    cnt_flags_t flags;
    logic       trig_lvl;
    logic       ref_lvl;

    assign mode = ocm_e'(mode_i);

    pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en_i      (cnt_en_i),
        .period_i  (period_i),
        .compare_i (compare_i),
        .cnt_o     (cnt_o),
        .flags_o   (flags)
    );

    pwm_trig_cond #(.SEL_W(FSEL_W), .SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig_i),
        .pol_i   (trig_pol_i),
        .sel_i   (filt_sel_i),
        .level_o (trig_lvl)
    );

    pwm_ref_gen u_ref (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .flags_i    (flags),
        .clr_en_i   (clr_en_i),
        .trig_lvl_i (trig_lvl),
        .ref_o      (ref_lvl)
    );

    assign update_o = flags.wrap;
    assign oc_ref_o = ref_lvl;
    assign oc_pin_o = out_en_i && (ref_lvl ^ out_pol_i);

endmodule

// File: rtl/pwm_clear_channel_chk.sv
module pwm_clear_channel_chk
    import pwm_clear_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en_i,
    input logic [2:0]       mode_i,
    input logic             clr_en_i,
    input logic             out_en_i,
    input logic             trig_lvl,
    input logic [CNT_W-1:0] cnt_o,
    input logic             update_o,
    input logic             oc_ref_o,
    input logic             oc_pin_o
);

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        update_o |=> (cnt_o == '0)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en_i && !update_o) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cnt_en_i |=> $stable(cnt_o)); // R1

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd5) |-> oc_ref_o); // R5

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd4) |-> !oc_ref_o); // R5

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (rst)
        (ocm_clearable(ocm_e'(mode_i)) && clr_en_i && trig_lvl) |-> !oc_ref_o); // R6

    AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (rst)
        (ocm_clearable(ocm_e'(mode_i)) && clr_en_i && trig_lvl && !update_o)
        |=> (!ocm_clearable(ocm_e'(mode_i)) || !oc_ref_o)); // R7

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_en_i |-> !oc_pin_o); // R13

endmodule

bind pwm_clear_channel pwm_clear_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en_i (cnt_en_i),
    .mode_i   (mode_i),
    .clr_en_i (clr_en_i),
    .out_en_i (out_en_i),
    .trig_lvl (trig_lvl),
    .cnt_o    (cnt_o),
    .update_o (update_o),
    .oc_ref_o (oc_ref_o),
    .oc_pin_o (oc_pin_o)
);

// File: tb/test_pwm_clear_channel.sv
`timescale 1ns/1ps
module test_pwm_clear_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [15:0] period = 16'd9;
    logic [15:0] compare = 16'd4;
    logic [2:0]  mode = 3'd6;
    logic        clr_en = 1'b0;
    logic        trig = 1'b0;
    logic        trig_pol = 1'b0;
    logic [1:0]  filt_sel = 2'd0;
    logic        out_pol = 1'b0;
    logic        out_en = 1'b1;
    logic        oc_ref;
    logic        oc_pin;
    logic [15:0] cnt;
    logic        upd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_clear_channel i_pwm_clear_channel (
        .clk        (clk),
        .rst        (rst),
        .cnt_en_i   (cnt_en),
        .period_i   (period),
        .compare_i  (compare),
        .mode_i     (mode),
        .clr_en_i   (clr_en),
        .trig_i     (trig),
        .trig_pol_i (trig_pol),
        .filt_sel_i (filt_sel),
        .out_pol_i  (out_pol),
        .out_en_i   (out_en),
        .oc_ref_o   (oc_ref),
        .oc_pin_o   (oc_pin),
        .cnt_o      (cnt),
        .update_o   (upd)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic goto_cnt(input int v);
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (int'(cnt) != v && g < 100);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(cnt), 0);
        check("R1 reset update", int'(upd), 0);
        check("R3 reset ref", int'(oc_ref), 0);
        check("R13 reset pin", int'(oc_pin), 0);
        rst = 1'b0;
    endtask

    task automatic t_counter;
        cnt_en = 1'b1;
        #1;
        check("R1 first update", int'(upd), 1);
        goto_cnt(0);
        repeat (9) @(negedge clk);
        check("R1 top count", int'(cnt), 9);
        check("R1 update at top", int'(upd), 1);
        @(negedge clk);
        check("R1 wrap to zero", int'(cnt), 0);
        goto_cnt(3);
        cnt_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 hold count", int'(cnt), 3);
        check("R1 no update while held", int'(upd), 0);
        cnt_en = 1'b1;
    endtask

    task automatic t_preload;
        goto_cnt(2);
        period  = 16'd5;
        compare = 16'd2;
        goto_cnt(3);
        check("R2 old compare kept", int'(oc_ref), 1);
        goto_cnt(9);
        check("R2 old period kept", int'(upd), 1);
        goto_cnt(3);
        check("R2 new compare used", int'(oc_ref), 0);
        goto_cnt(5);
        check("R2 new period used", int'(upd), 1);
        period  = 16'd9;
        compare = 16'd4;
        goto_cnt(0);
        goto_cnt(0);
    endtask

    task automatic t_pwm;
        mode = 3'd6;
        goto_cnt(3);
        check("R3 pwm a below", int'(oc_ref), 1);
        goto_cnt(4);
        check("R3 pwm a at compare", int'(oc_ref), 0);
        mode = 3'd7;
        goto_cnt(3);
        check("R3 pwm b below", int'(oc_ref), 0);
        goto_cnt(4);
        check("R3 pwm b at compare", int'(oc_ref), 1);
    endtask

    task automatic t_oc;
        mode = 3'd4;
        @(negedge clk);
        mode = 3'd1;
        goto_cnt(4);
        check("R4 set before match", int'(oc_ref), 0);
        @(negedge clk);
        check("R4 set after match", int'(oc_ref), 1);
        mode = 3'd0;
        goto_cnt(4);
        @(negedge clk);
        check("R4 frozen holds", int'(oc_ref), 1);
        mode = 3'd3;
        goto_cnt(4);
        check("R4 toggle before match", int'(oc_ref), 1);
        @(negedge clk);
        check("R4 toggle after match", int'(oc_ref), 0);
        mode = 3'd5;
        @(negedge clk);
        mode = 3'd2;
        goto_cnt(4);
        check("R4 clear before match", int'(oc_ref), 1);
        @(negedge clk);
        check("R4 clear after match", int'(oc_ref), 0);
    endtask

    task automatic t_forced;
        mode = 3'd5;
        #1;
        check("R5 force high", int'(oc_ref), 1);
        mode = 3'd4;
        goto_cnt(1);
        check("R5 force low under pwm window", int'(oc_ref), 0);
    endtask

    task automatic t_clear_basic;
        mode    = 3'd6;
        compare = 16'd8;
        goto_cnt(0);
        goto_cnt(0);
        clr_en   = 1'b1;
        filt_sel = 2'd0;
        goto_cnt(1);
        trig = 1'b1;
        @(negedge clk);
        check("R6 not yet cleared", int'(oc_ref), 1);
        @(negedge clk);
        check("R6 cleared after two cycles", int'(oc_ref), 0);
        trig = 1'b0;
        goto_cnt(6);
        check("R7 held low after trigger drop", int'(oc_ref), 0);
        goto_cnt(1);
        check("R7 released at update", int'(oc_ref), 1);
    endtask

    task automatic t_rearm;
        goto_cnt(5);
        trig = 1'b1;
        goto_cnt(2);
        check("R8 low across update", int'(oc_ref), 0);
        goto_cnt(3);
        trig = 1'b0;
        goto_cnt(6);
        check("R8 latched through new period", int'(oc_ref), 0);
        goto_cnt(1);
        check("R8 released one update later", int'(oc_ref), 1);
    endtask

    task automatic t_disabled;
        clr_en = 1'b0;
        goto_cnt(1);
        trig = 1'b1;
        goto_cnt(4);
        check("R10 no clear when disabled", int'(oc_ref), 1);
        trig = 1'b0;
        goto_cnt(1);
        check("R10 nothing latched", int'(oc_ref), 1);
    endtask

    task automatic t_forced_ignore;
        clr_en = 1'b1;
        mode   = 3'd5;
        trig   = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 forced high ignores clear", int'(oc_ref), 1);
        trig = 1'b0;
        repeat (4) @(negedge clk);
        mode = 3'd6;
        goto_cnt(2);
        check("R9 no latch left behind", int'(oc_ref), 1);
    endtask

    task automatic t_polarity;
        trig     = 1'b1;
        trig_pol = 1'b1;
        goto_cnt(0);
        goto_cnt(1);
        check("R11 high inactive when inverted", int'(oc_ref), 1);
        trig = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 low clears when inverted", int'(oc_ref), 0);
        trig = 1'b1;
        goto_cnt(1);
        check("R11 released", int'(oc_ref), 1);
        trig     = 1'b0;
        trig_pol = 1'b0;
    endtask

    task automatic t_filter;
        filt_sel = 2'd2;
        goto_cnt(0);
        goto_cnt(1);
        trig = 1'b1;
        goto_cnt(4);
        trig = 1'b0;
        goto_cnt(7);
        check("R12 short pulse ignored", int'(oc_ref), 1);
        goto_cnt(1);
        trig = 1'b1;
        goto_cnt(5);
        check("R12 not before N samples", int'(oc_ref), 1);
        trig = 1'b0;
        @(negedge clk);
        check("R12 clear after N samples", int'(oc_ref), 0);
        filt_sel = 2'd0;
        repeat (30) @(negedge clk);
        goto_cnt(1);
        check("R12 released after settle", int'(oc_ref), 1);
    endtask

    task automatic t_pin;
        mode    = 3'd5;
        out_pol = 1'b0;
        #1;
        check("R13 pin follows ref", int'(oc_pin), 1);
        out_pol = 1'b1;
        #1;
        check("R13 pin inverted", int'(oc_pin), 0);
        mode = 3'd4;
        #1;
        check("R13 inverted low ref", int'(oc_pin), 1);
        out_en = 1'b0;
        #1;
        check("R13 disabled idle", int'(oc_pin), 0);
        out_en  = 1'b1;
        out_pol = 1'b0;
        mode    = 3'd6;
    endtask

    initial begin
        t_reset;
        t_counter;
        t_preload;
        t_pwm;
        t_oc;
        t_forced;
        t_clear_basic;
        t_rearm;
        t_disabled;
        t_forced_ignore;
        t_polarity;
        t_filter;
        t_pin;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule